// File: doc/BRIEF.md
# Cascadable Nibble Magnitude Comparator

This block orders two unsigned operands and reports exactly one of three verdicts: greater, less or equal. It is built from identical nibble stages. Each stage compares its own 4-bit slices and also takes a three-wire verdict from the next less significant stage. When a stage's own slices differ, its verdict is final. When they match, the stage passes on the verdict it received. The result travels from the low nibble up to the high nibble, and the most significant stage drives the block's outputs.

The wrapper repeats the stage `NUM_STAGES` times, so any operand width that is a multiple of four can be built. The default of two stages gives an 8-bit comparator, with bits 3..0 in the lower stage and bits 7..4 in the upper stage. The lowest stage receives a fixed "equal" verdict, so operands that match in every nibble report equality. The block is purely combinational.

Top module: `mag_cmp_chain`

## Requirements
- R1: `gt_o` is 1 exactly when `a_i` is greater than `b_i` as an unsigned number.
- R2: `lt_o` is 1 exactly when `a_i` is less than `b_i` as an unsigned number.
- R3: `eq_o` is 1 exactly when `a_i` equals `b_i` in every bit.
- R4: For every input pair, exactly one of `gt_o`, `lt_o`, `eq_o` is 1.
- R5: If the nibbles at bits 7..4 differ, the result depends only on those nibbles; the contents of bits 3..0 of either operand have no effect.
- R6: If the nibbles at bits 7..4 are equal, the outputs equal the verdict of the comparison of bits 3..0.
- R7: Inside a stage, a slice counts as equal only when the per-bit XNOR is 1 at every bit position. A stage whose own slices differ ignores its cascade inputs.
- R8: The lowest stage receives the cascade verdict greater=0, less=0, equal=1.
- R9: The operand width is 4 × `NUM_STAGES`, and the stages are chained from least to most significant.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 4*NUM_STAGES (8) | Operand A, unsigned |
| b_i | input | 4*NUM_STAGES (8) | Operand B, unsigned |
| gt_o | output | 1 | A greater than B |
| lt_o | output | 1 | A less than B |
| eq_o | output | 1 | A equal to B |

## Verification
Inside each stage, the one-hot assertion assumes that the cascade verdict it receives is itself one-hot. That holds because the lowest stage is tied to "equal" and every other stage is fed by a stage that also obeys the rule. The operand assertions assume known (non-X) inputs and are skipped while any input is unknown. The bench drives every one of the 65,536 operand pairs of the default configuration, all with fully known values, so all of these assumptions hold. The sweep also covers every combination of equal and unequal high and low nibbles.

// File: rtl/mag_cmp_pkg.sv
package mag_cmp_pkg;
  localparam int unsigned NIB_W = 4;

  typedef struct packed {
    logic gt;
    logic lt;
    logic eq;
  } verdict_t;
endpackage

// File: rtl/nib_order.sv
module nib_order
  import mag_cmp_pkg::*;
#(
  parameter int unsigned W = NIB_W
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output verdict_t     res_o
);
  logic [W-1:0] same_bits;
  logic [W:0]   prefix_eq;
  logic [W-1:0] gt_terms;
  logic [W-1:0] lt_terms;

  assign prefix_eq[W] = 1'b1;

  // Scan from MSB: the first differing bit decides the order.
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign same_bits[i] = ~(a_i[i] ^ b_i[i]);
    assign prefix_eq[i] = prefix_eq[i+1] & same_bits[i];
    assign gt_terms[i]  = prefix_eq[i+1] & a_i[i] & ~b_i[i];
    assign lt_terms[i]  = prefix_eq[i+1] & ~a_i[i] & b_i[i];
  end

  assign res_o.gt = |gt_terms;
  assign res_o.lt = |lt_terms;
  assign res_o.eq = prefix_eq[0];

  always_comb begin
    if (!$isunknown({a_i, b_i})) begin
      assert_local_eq_R7 : assert (res_o.eq == (a_i == b_i))
        else $error("nib_order: equality mismatch");
      assert_local_onehot_R4 : assert ($countones(res_o) == 1)
        else $error("nib_order: verdict not one-hot");
    end
  end
endmodule

// File: rtl/verdict_merge.sv
module verdict_merge
  import mag_cmp_pkg::*;
(
  input  verdict_t own_i,
  input  verdict_t casc_i,
  output verdict_t res_o
);
  assign res_o = own_i.eq ? casc_i : own_i;

  always_comb begin
    if (!$isunknown({own_i, casc_i})) begin
      if (!own_i.eq) begin
        assert_ignore_casc_R7 : assert (res_o == own_i)
          else $error("verdict_merge: cascade leaked into decided stage");
      end else begin
        assert_pass_casc_R6 : assert (res_o == casc_i)
          else $error("verdict_merge: cascade not forwarded");
      end
      if ($countones(casc_i) == 1 && $countones(own_i) == 1) begin
        assert_merge_onehot_R4 : assert ($countones(res_o) == 1)
          else $error("verdict_merge: verdict not one-hot");
      end
    end
  end
endmodule

// File: rtl/mag_cmp_stage.sv
module mag_cmp_stage
  import mag_cmp_pkg::*;
#(
  parameter int unsigned W = NIB_W
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  verdict_t     casc_i,
  output verdict_t     res_o
);
  verdict_t own;

  nib_order #(.W(W)) u_order (
    .a_i  (a_i),
    .b_i  (b_i),
    .res_o(own)
  );

  verdict_merge u_merge (
    .own_i (own),
    .casc_i(casc_i),
    .res_o (res_o)
  );
endmodule

// File: rtl/mag_cmp_chain.sv
module mag_cmp_chain
  import mag_cmp_pkg::*;
#(
  parameter int unsigned NUM_STAGES = 2,
  localparam int unsigned OP_W = NIB_W * NUM_STAGES
) (
  input  logic [OP_W-1:0] a_i,
  input  logic [OP_W-1:0] b_i,
  output logic            gt_o,
  output logic            lt_o,
  output logic            eq_o
);
  verdict_t link [NUM_STAGES+1];

  // Seed for the least significant stage (R8).
  assign link[0] = '{gt: 1'b0, lt: 1'b0, eq: 1'b1};

  for (genvar s = 0; s < NUM_STAGES; s++) begin : g_stage
    mag_cmp_stage #(.W(NIB_W)) u_stage (
      .a_i   (a_i[s*NIB_W +: NIB_W]),
      .b_i   (b_i[s*NIB_W +: NIB_W]),
      .casc_i(link[s]),
      .res_o (link[s+1])
    );
  end

  assign gt_o = link[NUM_STAGES].gt;
  assign lt_o = link[NUM_STAGES].lt;
  assign eq_o = link[NUM_STAGES].eq;

  always_comb begin
    if (!$isunknown({a_i, b_i})) begin
      assert_gt_order_R1 : assert (gt_o == (a_i > b_i))
        else $error("mag_cmp_chain: gt wrong");
      assert_lt_order_R2 : assert (lt_o == (a_i < b_i))
        else $error("mag_cmp_chain: lt wrong");
      assert_eq_match_R3 : assert (eq_o == (a_i == b_i))
        else $error("mag_cmp_chain: eq wrong");
      assert_onehot_out_R4 : assert ($countones({gt_o, lt_o, eq_o}) == 1)
        else $error("mag_cmp_chain: outputs not one-hot");
    end
  end
endmodule

// File: tb/sim_mag_cmp_chain.sv
module sim_mag_cmp_chain;
  localparam int unsigned STAGES = 2;
  localparam int unsigned W = 4 * STAGES;

  logic         clk = 1'b0;
  logic [W-1:0] a, b;
  logic         gt, lt, eq;
  int           checks = 0;
  int           errors = 0;
  int           cycles = 0;

  always #2.5 clk = ~clk;

  mag_cmp_chain #(.NUM_STAGES(STAGES)) u0 (
    .a_i (a), .b_i (b),
    .gt_o(gt), .lt_o(lt), .eq_o(eq)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      errors = errors + 1;
      checks = checks + 1;
      $display("FAIL watchdog: actual %0d cycles, expected <= 150000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic apply(input logic [W-1:0] av, input logic [W-1:0] bv,
                       input string tag);
    logic [2:0] exp_v, act_v;
    @(negedge clk);
    a = av;
    b = bv;
    #1;
    exp_v = {av > bv, av < bv, av == bv};
    act_v = {gt, lt, eq};
    checks++;
    if (act_v !== exp_v) begin
      errors++;
      $display("FAIL %s: a=%0d b=%0d actual gt/lt/eq=%b expected %b",
               tag, av, bv, act_v, exp_v);
    end
  endtask

  initial begin
    a = '0;
    b = '0;
    // Initial state: zeros compare equal through the seeded chain (R8, R3).
    apply(8'd0, 8'd0, "R8");
    // Directed corner cases.
    apply(8'hFF, 8'hFF, "R3");
    apply(8'h80, 8'h7F, "R1");
    apply(8'h7F, 8'h80, "R2");
    apply(8'h5F, 8'h40, "R5");   // high nibble decides, low nibble ignored
    apply(8'h50, 8'h4F, "R5");
    apply(8'h43, 8'h4C, "R6");   // high equal, low decides
    apply(8'h4C, 8'h43, "R6");
    apply(8'h01, 8'h00, "R7");
    apply(8'h10, 8'h0F, "R9");
    // Exhaustive sweep; tag by which stage decides.
    for (int i = 0; i < (1 << W); i++) begin
      for (int j = 0; j < (1 << W); j++) begin
        logic [W-1:0] av, bv;
        av = W'(i);
        bv = W'(j);
        if (av[W-1 -: 4] != bv[W-1 -: 4])
          apply(av, bv, "R5/R1/R2/R4");
        else if (av[3:0] != bv[3:0])
          apply(av, bv, "R6/R1/R2/R4");
        else
          apply(av, bv, "R3/R4");
      end
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule